// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a processor execute stage. It is assembled from identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate and a four-way result selector. The slices are chained through their carry signals, so a carry travels from the least significant slice to the most significant one, one stage at a time. The default width is 32 bits.

Two control inputs select the function. The first is a single `subtract` line, which both inverts the B operand inside every slice and supplies the carry into the lowest slice. The second is a two-bit `opSel` field, which chooses which slice output becomes the result. The supported functions are:

- AND
- OR
- addition
- subtraction
- signed set-on-less-than

For set-on-less-than, the raw sum bit of the top slice is routed back into a spare selector input of slice 0. Every other slice has that input tied low. Beside the result, the block reports the carry out of the top slice, a signed overflow flag and an all-zero flag. Used together with subtraction, the all-zero flag gives an equality test for branch decisions.

Top module: `aluRipple`

## Requirements
- R1: With `subtract`=0 and `opSel`=2'b00, `result` equals `opA & opB`.
- R2: With `subtract`=0 and `opSel`=2'b01, `result` equals `opA | opB`.
- R3: With `subtract`=0 and `opSel`=2'b10, `result` equals `(opA + opB) mod 2^32`, and `carryOut` is bit 32 of the unsigned 33-bit sum.
- R4: With `subtract`=1 and `opSel`=2'b10, `result` equals `opA + ~opB + 1` modulo 2^32. `carryOut` is 1 exactly when `opA` >= `opB` when both are read as unsigned.
- R5: With `subtract`=1 and `opSel`=2'b11, bits 31..1 of `result` are 0 and bit 0 is bit 31 of `opA - opB`. This raw sign bit is used even when the subtraction overflows. For example, `opA`=0x7FFFFFFF and `opB`=0xFFFFFFFF give 1.
- R6: For the operations of R3 and R4, `overflow` is 1 exactly when the two adder inputs (A and the possibly inverted B) share a sign bit and the sum's sign bit differs from it. This is the same as the carry into the top slice differing from the carry out of it.
- R7: `zero` is 1 exactly when all 32 bits of `result` are 0. With subtraction it is 1 exactly when `opA` equals `opB`.
- R8: In every operation, `carryOut` and `overflow` come from the adder chain fed with A, B XOR `subtract`, and carry-in `subtract`, including when a logic result is selected.
- R9: With `subtract`=1, the logic selections use the inverted B operand. `opSel`=2'b00 gives `opA & ~opB` and `opSel`=2'b01 gives `opA | ~opB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subtract | input | 1 | Inverts B in every slice and sets the carry into slice 0 |
| opSel | input | 2 | Result select: 00 AND, 01 OR, 10 sum, 11 less-than |
| result | output | 32 | Selected result |
| carryOut | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Signed overflow of the adder chain |
| zero | output | 1 | High when every result bit is 0 |

## Verification
Additions are driven with operands chosen to separate the carry from the signed overflow:

- all ones plus one produces a carry with no overflow;
- the largest positive value plus one produces an overflow with no carry.

Subtractions are driven with equal operands, which must raise the zero flag, and with unequal operands in both unsigned orders, which exercises the borrow sense of the carry. Set-on-less-than is tried with:

- signed pairs where the operand signs differ and no overflow occurs, which checks that the compare is signed rather than unsigned;
- an overflowing pair, which confirms that the raw sign bit is passed through.

The logic operations are run with the subtract line both low and high, and with operands that make the hidden adder carry. This shows that B inversion reaches the logic gates and that the flags keep following the adder.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int ALU_WIDTH = 32;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } resultSel_e;

  typedef struct packed {
    logic       invertB;
    logic       carryIn;
    resultSel_e muxSel;
  } aluCtrl_t;

endpackage

// File: rtl/aluSlice.sv
module aluSlice (
  input  logic                  a,
  input  logic                  b,
  input  logic                  invertB,
  input  logic                  carryIn,
  input  logic                  less,
  input  alu_pkg::resultSel_e   muxSel,
  output logic                  result,
  output logic                  carryOut,
  output logic                  sumBit
);
  import alu_pkg::*;

  logic bEff;

  always_comb begin
    bEff     = b ^ invertB;
    sumBit   = a ^ bEff ^ carryIn;
    carryOut = (a & bEff) | (a & carryIn) | (bEff & carryIn);
    unique case (muxSel)
      SEL_AND:  result = a & bEff;
      SEL_OR:   result = a | bEff;
      SEL_SUM:  result = sumBit;
      default:  result = less;
    endcase
  end

endmodule

// File: rtl/aluControl.sv
module aluControl (
  input  logic               subtract,
  input  logic [1:0]         opSel,
  output alu_pkg::aluCtrl_t  ctrl
);
  import alu_pkg::*;

  // One line serves as both the B inversion and the carry into slice 0.
  always_comb begin
    ctrl.invertB = subtract;
    ctrl.carryIn = subtract;
    ctrl.muxSel  = resultSel_e'(opSel);
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath #(
  parameter int WIDTH = alu_pkg::ALU_WIDTH
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  alu_pkg::aluCtrl_t  ctrl,
  output logic [WIDTH-1:0]   result,
  output logic               carryOut,
  output logic               overflow
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sumBits;

  for (genvar i = 0; i < WIDTH; i++) begin : chain
    logic cInLocal;
    logic cOutLocal;
    logic lessLocal;
    logic resLocal;
    logic sumLocal;

    if (i == 0) begin : g_first
      assign cInLocal  = ctrl.carryIn;
      assign lessLocal = chain[MSB].sumLocal;
    end else begin : g_rest
      assign cInLocal  = chain[i-1].cOutLocal;
      assign lessLocal = 1'b0;
    end

    aluSlice u_slice (
      .a        (opA[i]),
      .b        (opB[i]),
      .invertB  (ctrl.invertB),
      .carryIn  (cInLocal),
      .less     (lessLocal),
      .muxSel   (ctrl.muxSel),
      .result   (resLocal),
      .carryOut (cOutLocal),
      .sumBit   (sumLocal)
    );

    assign result[i]  = resLocal;
    assign sumBits[i] = sumLocal;
  end

  assign carryOut = chain[MSB].cOutLocal;
  assign overflow = chain[MSB].cInLocal ^ chain[MSB].cOutLocal;

  // Assertions guarding the slice chain
  logic [WIDTH-1:0] bRef;
  logic [WIDTH:0]   sumRef;

  always_comb begin
    bRef   = ctrl.invertB ? ~opB : opB;
    sumRef = {1'b0, opA} + {1'b0, bRef} + {{WIDTH{1'b0}}, ctrl.carryIn};

    if (ctrl.muxSel == SEL_AND)
      a_r1_and_result: assert (result == (opA & bRef));
    if (ctrl.muxSel == SEL_OR)
      a_r9_or_uses_eff_b: assert (result == (opA | bRef));

    a_r8_carry_follows_adder: assert (carryOut == sumRef[WIDTH]);

    if (ctrl.muxSel == SEL_SUM) begin
      a_r3_sum_result: assert (result == sumRef[MSB:0] && result == sumBits);
      a_r6_overflow_sign: assert (overflow ==
        ((opA[MSB] == bRef[MSB]) && (result[MSB] != opA[MSB])));
    end

    if (ctrl.muxSel == SEL_LESS)
      a_r5_less_bit: assert (result[MSB:1] == '0 && result[0] == sumRef[MSB]);
  end

endmodule

// File: rtl/aluRipple.sv
module aluRipple (
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subtract,
  input  logic [1:0]  opSel,
  output logic [31:0] result,
  output logic        carryOut,
  output logic        overflow,
  output logic        zero
);
  import alu_pkg::*;

  aluCtrl_t ctrl;

  aluControl u_ctrl (
    .subtract (subtract),
    .opSel    (opSel),
    .ctrl     (ctrl)
  );

  aluDatapath #(.WIDTH(ALU_WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow)
  );

  assign zero = ~|result;

  always_comb begin
    if (subtract && opSel == 2'b10)
      a_r7_zero_equality: assert (zero == (opA == opB));
    if (subtract && opSel == 2'b10)
      a_r4_sub_borrow: assert (carryOut == (opA >= opB));
  end

endmodule

// File: tb/sim_aluRipple.sv
module sim_aluRipple;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic [31:0] opA = '0, opB = '0;
  logic        subtract = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] result;
  logic        carryOut, overflow, zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  aluRipple u0 (
    .opA(opA), .opB(opB), .subtract(subtract), .opSel(opSel),
    .result(result), .carryOut(carryOut), .overflow(overflow), .zero(zero)
  );

  // Expected outputs, built from the requirements
  task automatic runCase(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic sub, input logic [1:0] sel);
    logic [31:0] bEff, expRes;
    logic [32:0] full;
    logic        expOvf;
    @(posedge clk);
    opA = a; opB = b; subtract = sub; opSel = sel;
    bEff   = sub ? ~b : b;
    full   = {1'b0, a} + {1'b0, bEff} + {32'd0, sub};
    expOvf = (a[31] == bEff[31]) && (full[31] != a[31]);
    case (sel)
      2'b00:   expRes = a & bEff;
      2'b01:   expRes = a | bEff;
      2'b10:   expRes = full[31:0];
      default: expRes = {31'd0, full[31]};
    endcase
    @(negedge clk);
    checks++;
    if (result !== expRes || carryOut !== full[32] || overflow !== expOvf ||
        zero !== (expRes == 32'd0)) begin
      fails++;
      $display("FAIL %s: a=%h b=%h sub=%0d sel=%0d got res=%h c=%0d v=%0d z=%0d exp res=%h c=%0d v=%0d z=%0d",
               req, a, b, sub, sel, result, carryOut, overflow, zero,
               expRes, full[32], expOvf, expRes == 32'd0);
    end
  endtask

  task automatic testIdle();       // R7 reset state: zero operands AND to zero
    runCase("R7", 32'd0, 32'd0, 1'b0, 2'b00);
  endtask

  task automatic testLogic();
    runCase("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b00);
    runCase("R2", 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b01);
    runCase("R1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 2'b00);
  endtask

  task automatic testAdd();
    runCase("R3", 32'd40, 32'd2, 1'b0, 2'b10);
    runCase("R3", 32'hFFFF_FFFF, 32'd1, 1'b0, 2'b10);  // carry, wraps to zero
    runCase("R6", 32'h7FFF_FFFF, 32'd1, 1'b0, 2'b10);  // positive overflow
    runCase("R6", 32'h8000_0000, 32'h8000_0000, 1'b0, 2'b10);
  endtask

  task automatic testSub();
    runCase("R4", 32'd5, 32'd7, 1'b1, 2'b10);
    runCase("R4", 32'd7, 32'd5, 1'b1, 2'b10);
    runCase("R7", 32'h1234_5678, 32'h1234_5678, 1'b1, 2'b10);
    runCase("R6", 32'h8000_0000, 32'd1, 1'b1, 2'b10);
  endtask

  task automatic testLess();
    runCase("R5", 32'hFFFF_FFF9, 32'd5, 1'b1, 2'b11);  // -7 < 5
    runCase("R5", 32'd5, 32'hFFFF_FFF9, 1'b1, 2'b11);  // 5 < -7 false
    runCase("R5", 32'd3, 32'd3, 1'b1, 2'b11);
    runCase("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b11); // raw sign on overflow
  endtask

  task automatic testHiddenAdder();
    runCase("R8", 32'hFFFF_FFFF, 32'd1, 1'b0, 2'b00);
    runCase("R8", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 2'b01);
    runCase("R9", 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b1, 2'b00);
    runCase("R9", 32'h0000_0011, 32'hFFFF_0000, 1'b1, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testIdle();
    testLogic();
    testAdd();
    testSub();
    testLess();
    testHiddenAdder();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule